// File: doc/BRIEF.md
# Dual-I/O Serial Flash Read Responder

This block sits on the target side of a serial flash bus and answers dual-I/O fast reads from a small built-in byte array. It can stand in for a flash device in a subsystem. The master lowers chip select and shifts an 8-bit command on data line 0. It then sends a 24-bit address two bits per clock and runs a number of dummy clocks. After that the block returns bytes two bits per falling serial clock edge until chip select rises. The read pointer steps through the array and wraps at its top.

A busy input stands for a program or erase already in progress. If busy is high when the command completes, the transaction is rejected and the block stays silent until chip select rises again. The serial pins are oversampled in the `clk` domain, so the serial clock must be several times slower than `clk`. The data lines are split into input, output and output-enable, for a pad ring to combine.

Top module: `dual_read_responder`

## Requirements
- R1: Only command byte 0xBB, shifted MSB first on `io_i[0]` over the first 8 rising serial clock edges after chip select falls, starts a read. Any other command causes no driving until chip select rises.
- R2: The address is taken over the next 12 rising edges, most significant pair first, with `io_i[1]` as the higher bit of each pair. Its low ADDR_BITS bits select the starting byte of the array.
- R3: DUMMY_CLKS further rising edges (default 4) are skipped. The first falling edge after the last of them enables the outputs and drives the first pair. Before that, `io_oe` stays low.
- R4: Each falling edge in the data phase drives the next pair of the current byte: first bits 7/6, then 5/4, 3/2 and 1/0, with the higher bit on `io_o[1]`. The byte at index i is the low 8 bits of i*37, XOR 0x5A.
- R5: After the fourth pair of a byte, the pointer advances by one. From index 2**ADDR_BITS-1 it wraps to 0.
- R6: A high level on `cs_n` aborts any phase. It clears `io_oe` and `io_o`, and the next low level starts again at the command phase.
- R7: If `busy` is high when the eighth command bit is taken, the read is rejected and nothing is driven for the rest of the transaction. Reads with `busy` low are unaffected by earlier rejections.
- R8: `io_oe` is low after reset and outside the data phase of an accepted read. `io_o` is 0 whenever `io_oe` is low.
- R9: Every pin change takes effect at the outputs on the second rising `clk` edge after it. The serial clock half period must be at least 3 `clk` periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | High while a write-type operation is in progress |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the master |
| io_i | input | 2 | Data lines as seen at the pads (bit 1 = line 1) |
| io_o | output | 2 | Data driven toward the pads |
| io_oe | output | 1 | Output enable for both data lines |

## Verification
A wrong bit or phase count shifts the moment `io_oe` rises, so it shows on the first clock of the data phase. A wrong pointer or pair index shows as a wrong pair within the same serial clock. Missed synchronisation or abort logic shows as a two-cycle offset against the reference model within one `clk` period. Rejection errors show as the outputs being driven during a rejected transaction.

// File: rtl/dual_read_responder.sv
module dual_read_responder #(
  parameter int ADDR_BITS  = 8,
  parameter int DUMMY_CLKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic [1:0] io_i,
  output logic [1:0] io_o,
  output logic       io_oe
);
  localparam int DEPTH = 1 << ADDR_BITS;
  localparam int CW = 5;
  localparam logic [7:0] CMD_DUAL = 8'hBB;

  typedef enum logic [2:0] {PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA, PH_DROP} phase_t;

  logic sclk_q1, sclk_q2, cs_q1;
  logic [1:0] io_q1;
  phase_t phase;
  logic [CW-1:0] cnt;
  logic [7:0] op_sr;
  logic [23:0] addr_sr;
  logic [ADDR_BITS-1:0] ptr;
  logic [1:0] pair;
  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_fill
    assign mem[g] = 8'(g * 37) ^ 8'h5A;
  end

  wire rise = sclk_q1 & ~sclk_q2;
  wire fall = ~sclk_q1 & sclk_q2;
  wire [7:0] op_next = {op_sr[6:0], io_q1[0]};
  wire [23:0] addr_next = {addr_sr[21:0], io_q1};
  wire [7:0] cur_byte = mem[ptr];
  wire [7:0] shifted = cur_byte << {pair, 1'b0};
  wire data_ph = (phase == PH_DATA);
  wire drop_ph = (phase == PH_DROP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q1 <= 1'b0;
      sclk_q2 <= 1'b0;
      cs_q1   <= 1'b1;
      io_q1   <= '0;
      phase   <= PH_CMD;
      cnt     <= '0;
      op_sr   <= '0;
      addr_sr <= '0;
      ptr     <= '0;
      pair    <= '0;
      io_oe   <= 1'b0;
      io_o    <= '0;
    end else begin
      sclk_q1 <= sclk;
      sclk_q2 <= sclk_q1;
      cs_q1   <= cs_n;
      io_q1   <= io_i;
      if (cs_q1) begin
        phase <= PH_CMD;
        cnt   <= '0;
        pair  <= '0;
        io_oe <= 1'b0;
        io_o  <= '0;
      end else if (rise) begin
        case (phase)
          PH_CMD: begin
            op_sr <= op_next;
            if (cnt == CW'(7)) begin
              cnt   <= '0;
              phase <= (op_next == CMD_DUAL && !busy) ? PH_ADDR : PH_DROP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_ADDR: begin
            addr_sr <= addr_next;
            if (cnt == CW'(11)) begin
              cnt   <= '0;
              ptr   <= addr_next[ADDR_BITS-1:0];
              phase <= (DUMMY_CLKS == 0) ? PH_DATA : PH_DUMMY;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_DUMMY: begin
            if (cnt == CW'(DUMMY_CLKS - 1)) begin
              cnt   <= '0;
              phase <= PH_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end else if (fall && data_ph) begin
        io_oe <= 1'b1;
        io_o  <= shifted[7:6];
        pair  <= pair + 1'b1;
        if (pair == 2'd3) ptr <= ptr + 1'b1;
      end
    end
  end
endmodule

module dual_read_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       cs_q1,
  input logic       fall,
  input logic       data_ph,
  input logic       drop_ph,
  input logic       io_oe,
  input logic [1:0] io_o
);
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) |=> !io_oe && io_o == 2'b00);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ph |-> !io_oe);
  p_zero_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !io_oe |-> io_o == 2'b00);
  p_reject_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ph |-> !io_oe);
  p_hold_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fall && !cs_q1 |=> $stable(io_o) && $stable(io_oe));
  p_enable_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_oe) |-> $past(fall));
endmodule

bind dual_read_responder dual_read_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_q1(cs_q1), .fall(fall),
  .data_ph(data_ph), .drop_ph(drop_ph), .io_oe(io_oe), .io_o(io_o)
);

// File: tb/tb_dual_read_responder.sv
`timescale 1ns/1ps
module tb_dual_read_responder;
  localparam int AB = 8;
  localparam int DC = 4;
  localparam int DEPTH = 1 << AB;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busy = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic [1:0] io_i = 2'b00;
  logic [1:0] io_o;
  logic io_oe;

  dual_read_responder #(.ADDR_BITS(AB), .DUMMY_CLKS(DC)) dut (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cs_n(cs_n), .sclk(sclk),
    .io_i(io_i), .io_o(io_o), .io_oe(io_oe));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  string tag = "R8";
  bit finished = 0;

  int m_phase = 0, m_cnt = 0, m_op = 0, m_addr = 0, m_ptr = 0, m_pair = 0;
  bit m_oe = 0;
  bit [1:0] m_o = 0;
  bit prev_oe = 0;
  bit [1:0] prev_o = 0;
  bit last_sclk = 0;
  bit any_oe = 0;

  function automatic logic [7:0] byte_at(int i);
    return 8'((i * 37) & 255) ^ 8'h5A;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    checks++;
    if (io_oe !== prev_oe || io_o !== prev_o) begin
      errors++;
      $display("FAIL R9/%s cycle compare at %0t: actual oe=%0b o=%0h expected oe=%0b o=%0h",
               tag, $time, io_oe, io_o, prev_oe, prev_o);
    end
    prev_oe = m_oe;
    prev_o  = m_o;
  end

  task automatic apply(bit cs, bit sck, bit [1:0] d);
    logic [7:0] b;
    @(negedge clk);
    cs_n = cs; sclk = sck; io_i = d;
    if (cs) begin
      m_phase = 0; m_cnt = 0; m_pair = 0; m_oe = 0; m_o = 0;
    end else if (sck && !last_sclk) begin
      case (m_phase)
        0: begin
          m_op = ((m_op << 1) | d[0]) & 255;
          m_cnt++;
          if (m_cnt == 8) begin m_cnt = 0; m_phase = (m_op == 8'hBB && !busy) ? 1 : 4; end
        end
        1: begin
          m_addr = ((m_addr << 2) | d) & 24'hFFFFFF;
          m_cnt++;
          if (m_cnt == 12) begin m_cnt = 0; m_ptr = m_addr % DEPTH; m_phase = (DC == 0) ? 3 : 2; end
        end
        2: begin
          m_cnt++;
          if (m_cnt == DC) begin m_cnt = 0; m_phase = 3; end
        end
        default: ;
      endcase
    end else if (!sck && last_sclk && m_phase == 3) begin
      b = byte_at(m_ptr);
      m_oe = 1;
      m_o = 2'((b >> (6 - 2 * m_pair)) & 3);
      m_pair++;
      if (m_pair == 4) begin m_pair = 0; m_ptr = (m_ptr + 1) % DEPTH; end
    end
    last_sclk = sck;
  endtask

  task automatic sclk_cycle(bit [1:0] d, output bit [1:0] seen);
    apply(0, 0, d);
    repeat (HALF - 1) @(negedge clk);
    seen = io_o;
    any_oe |= io_oe;
    apply(0, 1, d);
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic end_xfer();
    apply(1, 1, 2'b00);
    repeat (HALF) @(negedge clk);
    apply(1, 0, 2'b00);
    repeat (2 * HALF) @(negedge clk);
    check(io_oe == 0 && io_o == 0, "R6", "released after cs high", {io_oe, io_o}, 0);
  endtask

  task automatic send_read(logic [7:0] op, logic [23:0] addr, int nbytes, int stop_pairs,
                           output logic [7:0] got [8]);
    bit [1:0] seen;
    logic [7:0] v;
    int pairs = 0;
    any_oe = 0;
    apply(0, 0, 2'b00);
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 8; i++) sclk_cycle({1'b0, op[7 - i]}, seen);
    for (int i = 0; i < 12; i++) sclk_cycle(addr[23 - 2 * i -: 2], seen);
    for (int i = 0; i < DC; i++) sclk_cycle(2'b00, seen);
    repeat (2) @(negedge clk);
    if (op == 8'hBB && !busy)
      check(any_oe == 0, "R3", "no drive before data phase", any_oe, 0);
    for (int b = 0; b < nbytes; b++) begin
      v = 0;
      for (int p = 0; p < 4; p++) begin
        if (stop_pairs >= 0 && pairs == stop_pairs) break;
        sclk_cycle(2'b00, seen);
        if (b == 0 && p == 0 && op == 8'hBB && !busy)
          check(any_oe == 1, "R3", "enabled on first data fall", any_oe, 1);
        v = {v[5:0], seen};
        pairs++;
      end
      got[b] = v;
    end
    end_xfer();
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] got [8];
    repeat (3) @(negedge clk);
    check(io_oe == 0 && io_o == 0, "R8", "reset state", {io_oe, io_o}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    tag = "R4";
    send_read(8'hBB, 24'h000010, 3, -1, got);
    for (int k = 0; k < 3; k++)
      check(got[k] == byte_at(16 + k), "R4", "byte from 0x10 (R1 R2)", got[k], byte_at(16 + k));

    tag = "R5";
    send_read(8'hBB, 24'hABCDFE, 4, -1, got);
    for (int k = 0; k < 4; k++)
      check(got[k] == byte_at((254 + k) % DEPTH), "R5", "wrap past top (R2)", got[k],
            byte_at((254 + k) % DEPTH));

    tag = "R1";
    send_read(8'h3B, 24'h000010, 2, -1, got);
    check(any_oe == 0, "R1", "other opcode silent", any_oe, 0);

    tag = "R7";
    busy = 1;
    send_read(8'hBB, 24'h000040, 2, -1, got);
    check(any_oe == 0, "R7", "busy rejects read", any_oe, 0);
    busy = 0;
    send_read(8'hBB, 24'h000040, 1, -1, got);
    check(got[0] == byte_at(64), "R7", "read after rejection", got[0], byte_at(64));

    tag = "R6";
    send_read(8'hBB, 24'h000077, 2, 5, got);
    send_read(8'hBB, 24'h000020, 2, -1, got);
    for (int k = 0; k < 2; k++)
      check(got[k] == byte_at(32 + k), "R6", "fresh read after abort", got[k], byte_at(32 + k));

    tag = "R2";
    send_read(8'hBB, 24'h5A5A81, 1, -1, got);
    check(got[0] == byte_at(8'h81), "R2", "high address bits masked", got[0], byte_at(8'h81));

    repeat (8) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule